// File: doc/BRIEF.md
# Destination Address Filter

This block decides whether a received frame is kept, judging only its 6-byte destination address. The address arrives as a byte stream. A start-of-frame flag marks byte 0, which is the first byte on the wire. Once the sixth byte is in, the block computes a 32-bit bit-serial hash CRC over the 48 address bits, one bit per clock. It then produces a single verdict pulse: `done_o` is high for one cycle and `accept_o` is qualified by it.

The acceptance rules depend on three receive-configuration bits and two programmed tables. One table is an exact-match station address. The other is a 64-bit multicast mask, indexed by the top six bits of the hash. Both tables are loaded through a byte write port that carries an index. A caller streams the address, waits for `done_o`, and treats `accept_o` in that cycle as the keep/drop decision. Address bytes that arrive while a verdict is being computed are dropped.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `done_o`, `accept_o` and `busy_o` are all 0.
- R2: When `rx_cfg_i` bit 4 (value 0x10) is set, every address is accepted.
- R3: An all-ones address is broadcast. Without bit 4 set, it is accepted exactly when `rx_cfg_i` bit 2 (value 0x04) is set.
- R4: A multicast address is any non-broadcast address whose byte 0 has bit 0 set. Without bit 4 set, it is accepted only when `rx_cfg_i` bit 3 (value 0x08) is set and mask bit `h` is set. Bit `h` is bit `h&7` of mask byte `h>>3`.
- R5: The hash `h` is computed as follows. The CRC starts at all ones. Address bytes are fed in order 0 to 5, each least significant bit first. For each bit, carry = CRC[31] XOR input bit. The CRC then shifts left by one, and if carry is 1 it becomes (CRC XOR 0x04C11DB6) OR 1. `h` is CRC[31:26] after the 48th bit.
- R6: Any other address is accepted only when all six bytes equal station bytes 0 to 5, where byte 0 is compared with the first byte received.
- R7: `done_o` is a single-cycle pulse that goes high 49 clock edges after the edge that captures the sixth address byte. `accept_o` is 0 whenever `done_o` is 0.
- R8: `busy_o` is high from the cycle after the sixth byte up to the verdict cycle. Bytes presented during that window, including ones flagged as start of frame, do not change the verdict.
- R9: A byte with `in_sof_i` restarts address collection at byte 0, even in the middle of an address. A byte without `in_sof_i` is ignored while no address is being collected.
- R10: A write with `wr_sel_i`=0 loads station byte `wr_idx_i`, for indices 0 to 5. Indices 6 and 7 are ignored. A write with `wr_sel_i`=1 loads mask byte `wr_idx_i`, for indices 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_cfg_i | input | 8 | Receive configuration: bit 4 = accept all, bit 3 = multicast enable, bit 2 = broadcast enable |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 1 | Table select: 0 = station address, 1 = multicast mask |
| wr_idx_i | input | 3 | Byte index within the selected table |
| wr_data_i | input | 8 | Byte to write |
| in_valid_i | input | 1 | Address byte strobe |
| in_sof_i | input | 1 | Marks byte 0 of an address |
| in_data_i | input | 8 | Address byte |
| busy_o | output | 1 | Hash in progress; input bytes are dropped |
| done_o | output | 1 | Single-cycle verdict strobe |
| accept_o | output | 1 | Frame accepted, valid with `done_o` |

## Verification
Three kinds of internal fault each show up within one address at the verdict pulse. A wrong CRC step or bit order selects the wrong mask bit, so a multicast address that should hit is rejected once only its own mask bit is set. A miscounted byte or hash step moves `done_o` off its fixed 49-edge position. A collection counter that keeps listening during the hash lets junk bytes change the verdict of the address being judged, or starts a spurious second verdict.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
   localparam int unsigned OCTET_W = 8;
   localparam logic [31:0] HASH_POLY = 32'h04C1_1DB6;
   localparam int unsigned CFG_ALL_BIT   = 4;
   localparam int unsigned CFG_MCAST_BIT = 3;
   localparam int unsigned CFG_BCAST_BIT = 2;
   typedef enum logic [1:0] {CAP_IDLE, CAP_COLLECT, CAP_HOLD} cap_state_e;
endpackage

// File: rtl/dafilt_tables.sv
module dafilt_tables #(
   parameter int unsigned STA_BYTES = 6,
   parameter int unsigned MSK_BYTES = 8,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic                   wr_sel_i,
   input  logic [IDX_W-1:0]       wr_idx_i,
   input  logic [7:0]             wr_data_i,
   output logic [8*STA_BYTES-1:0] station_o,
   output logic [8*MSK_BYTES-1:0] mask_o
);
   if ((1 << IDX_W) < MSK_BYTES || (1 << IDX_W) < STA_BYTES) begin : g_chk_idx
      $error("dafilt_tables: index too narrow");
   end

   logic [7:0] sta_q [STA_BYTES];
   logic [7:0] msk_q [MSK_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STA_BYTES; i++) sta_q[i] <= '0;
         for (int i = 0; i < MSK_BYTES; i++) msk_q[i] <= '0;
      end else if (wr_en_i) begin
         for (int i = 0; i < STA_BYTES; i++)
            if (!wr_sel_i && wr_idx_i == IDX_W'(i)) sta_q[i] <= wr_data_i;
         for (int i = 0; i < MSK_BYTES; i++)
            if (wr_sel_i && wr_idx_i == IDX_W'(i)) msk_q[i] <= wr_data_i;
      end
   end

   for (genvar g = 0; g < STA_BYTES; g++) begin : g_sta
      assign station_o[8*g +: 8] = sta_q[g];
   end
   for (genvar g = 0; g < MSK_BYTES; g++) begin : g_msk
      assign mask_o[8*g +: 8] = msk_q[g];
   end

   // R10: out-of-range station index leaves the station table untouched
   assert_sta_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_sel_i && int'(wr_idx_i) >= int'(STA_BYTES)) |=> $stable(station_o));
endmodule

// File: rtl/dafilt_capture.sv
module dafilt_capture
   import dafilt_pkg::*;
#(
   parameter int unsigned NBYTES = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid_i,
   input  logic                in_sof_i,
   input  logic [7:0]          in_data_i,
   input  logic                release_i,
   output logic                start_o,
   output logic [8*NBYTES-1:0] addr_next_o,
   output logic [8*NBYTES-1:0] addr_o,
   output logic                busy_o
);
   localparam int unsigned CW = (NBYTES > 2) ? $clog2(NBYTES) : 1;
   localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

   if (NBYTES < 2) begin : g_chk_len
      $error("dafilt_capture: need at least two bytes");
   end

   cap_state_e          state_q;
   logic [CW-1:0]       cnt_q;
   logic [8*NBYTES-1:0] addr_q;
   logic                take_more;

   assign take_more = (state_q == CAP_COLLECT) && in_valid_i && !in_sof_i;
   assign start_o   = take_more && (cnt_q == LAST);

   always_comb begin
      addr_next_o = addr_q;
      addr_next_o[8*int'(cnt_q) +: 8] = in_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAP_IDLE;
         cnt_q   <= '0;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            CAP_IDLE, CAP_COLLECT: begin
               if (in_valid_i && in_sof_i) begin
                  addr_q[7:0] <= in_data_i;
                  cnt_q       <= CW'(1);
                  state_q     <= CAP_COLLECT;
               end else if (take_more) begin
                  addr_q <= addr_next_o;
                  if (cnt_q == LAST) state_q <= CAP_HOLD;
                  else               cnt_q   <= cnt_q + CW'(1);
               end
            end
            CAP_HOLD: if (release_i) state_q <= CAP_IDLE;
            default:  state_q <= CAP_IDLE;
         endcase
      end
   end

   assign addr_o = addr_q;
   assign busy_o = (state_q == CAP_HOLD);

   // R8: while held, the captured address and the busy flag stay put
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !release_i) |=> (busy_o && $stable(addr_o)));
endmodule

// File: rtl/dafilt_hash_serial.sv
module dafilt_hash_serial #(
   parameter int unsigned      IN_BITS = 48,
   parameter int unsigned      CRC_W   = 32,
   parameter logic [CRC_W-1:0] POLY    = 32'h04C1_1DB6,
   parameter int unsigned      HASH_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [IN_BITS-1:0] data_i,
   output logic               done_o,
   output logic [HASH_W-1:0]  hash_o
);
   localparam int unsigned CNT_W = $clog2(IN_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(IN_BITS - 1);
   localparam logic [CRC_W-1:0] LSB1 = CRC_W'(1);

   if (HASH_W > CRC_W) begin : g_chk_hash
      $error("dafilt_hash_serial: hash wider than CRC");
   end

   logic [CRC_W-1:0]   crc_q, crc_step;
   logic [IN_BITS-1:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               run_q, done_q;

   always_comb begin
      crc_step = {crc_q[CRC_W-2:0], 1'b0};
      if (crc_q[CRC_W-1] ^ sh_q[0]) crc_step = (crc_step ^ POLY) | LSB1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q  <= '0;
         sh_q   <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            crc_q <= '1;
            sh_q  <= data_i;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            crc_q <= crc_step;
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == LAST) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign hash_o = crc_q[CRC_W-1 -: HASH_W];

   // R7: completion is a one-cycle pulse that only follows a running hash
   assert_hash_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_hash_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(run_q));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
   import dafilt_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned MASK_BYTES = 8,
   parameter int unsigned CRC_W      = 32,
   parameter logic [CRC_W-1:0] POLY  = HASH_POLY,
   parameter int unsigned WIDX_W     = $clog2(MASK_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        rx_cfg_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [WIDX_W-1:0] wr_idx_i,
   input  logic [7:0]        wr_data_i,
   input  logic              in_valid_i,
   input  logic              in_sof_i,
   input  logic [7:0]        in_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              accept_o
);
   localparam int unsigned ADDR_W = OCTET_W * ADDR_BYTES;
   localparam int unsigned MASK_W = OCTET_W * MASK_BYTES;
   localparam int unsigned HASH_W = $clog2(MASK_W);

   if ((1 << HASH_W) != MASK_W) begin : g_chk_mask
      $error("dest_addr_filter: mask size must be a power of two");
   end

   logic [ADDR_W-1:0] station, cap_addr, cap_next;
   logic [MASK_W-1:0] mask;
   logic [HASH_W-1:0] hash;
   logic              cap_start, hash_done, cap_busy;
   logic              is_bcast, is_mcast, uni_hit, verdict;
   logic              done_q, accept_q;
   logic              unused_cfg;

   assign unused_cfg = ^{rx_cfg_i[7:5], rx_cfg_i[1:0]};

   dafilt_tables #(.STA_BYTES(ADDR_BYTES), .MSK_BYTES(MASK_BYTES), .IDX_W(WIDX_W)) tables_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .station_o(station), .mask_o(mask));

   dafilt_capture #(.NBYTES(ADDR_BYTES)) capture_i (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_sof_i(in_sof_i),
      .in_data_i(in_data_i), .release_i(hash_done), .start_o(cap_start),
      .addr_next_o(cap_next), .addr_o(cap_addr), .busy_o(cap_busy));

   dafilt_hash_serial #(.IN_BITS(ADDR_W), .CRC_W(CRC_W), .POLY(POLY), .HASH_W(HASH_W)) hash_i (
      .clk(clk), .rst_n(rst_n), .start_i(cap_start), .data_i(cap_next),
      .done_o(hash_done), .hash_o(hash));

   always_comb begin
      is_bcast = &cap_addr;
      is_mcast = cap_addr[0] && !is_bcast;
      uni_hit  = (cap_addr == station);
      if (rx_cfg_i[CFG_ALL_BIT])  verdict = 1'b1;
      else if (is_bcast)          verdict = rx_cfg_i[CFG_BCAST_BIT];
      else if (is_mcast)          verdict = rx_cfg_i[CFG_MCAST_BIT] && mask[hash];
      else                        verdict = uni_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         accept_q <= 1'b0;
      end else begin
         done_q   <= hash_done;
         accept_q <= hash_done && verdict;
      end
   end

   assign busy_o   = cap_busy;
   assign done_o   = done_q;
   assign accept_o = accept_q;

   assert_accept_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> done_o);
   assert_verdict_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   assert_accept_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(rx_cfg_i[CFG_ALL_BIT])) |-> accept_o);
   assert_bcast_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && accept_o && $past(!rx_cfg_i[CFG_ALL_BIT] && (&cap_addr)))
      |-> $past(rx_cfg_i[CFG_BCAST_BIT]));
   assert_mcast_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && accept_o && $past(!rx_cfg_i[CFG_ALL_BIT] && cap_addr[0] && !(&cap_addr)))
      |-> $past(rx_cfg_i[CFG_MCAST_BIT]));
endmodule

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   localparam logic [47:0] STA = 48'h5544_3322_1102;
   // {cfg, address}; address byte 0 in bits [7:0]
   localparam logic [55:0] VECS [NVEC] = '{
      {8'h00, STA},
      {8'h00, 48'h5644_3322_1102},
      {8'h00, 48'h5544_3322_1104},
      {8'h00, 48'hFFFF_FFFF_FFFF},
      {8'h04, 48'hFFFF_FFFF_FFFF},
      {8'h08, 48'h0100_005E_0001},
      {8'h10, 48'h0000_0000_00AA},
      {8'h10, 48'hFFFF_FFFF_FFFF},
      {8'h0C, 48'h0000_0000_00AA},
      {8'h0C, STA}
   };

   logic clk = 0, rst_n = 0;
   logic [7:0] rx_cfg = 0, wr_data = 0, in_data = 0;
   logic wr_en = 0, wr_sel = 0, in_valid = 0, in_sof = 0;
   logic [2:0] wr_idx = 0;
   logic busy, done, accept;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [47:0] sta_m = '0;
   logic [63:0] msk_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dest_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .rx_cfg_i(rx_cfg), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_idx_i(wr_idx), .wr_data_i(wr_data), .in_valid_i(in_valid), .in_sof_i(in_sof),
      .in_data_i(in_data), .busy_o(busy), .done_o(done), .accept_o(accept));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] ref_hash(input logic [47:0] a);
      logic [31:0] c = '1;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b = a[8*i +: 8];
         for (int j = 0; j < 8; j++) begin
            bit cy = c[31] ^ b[0];
            c = c << 1;
            b = b >> 1;
            if (cy) c = (c ^ 32'h04C1_1DB6) | 32'h1;
         end
      end
      return c[31:26];
   endfunction

   function automatic bit ref_accept(input logic [47:0] a, input logic [7:0] cfg);
      if (cfg[4]) return 1;
      if (a == '1) return cfg[2];
      if (a[0]) return cfg[3] && msk_m[ref_hash(a)];
      return a == sta_m;
   endfunction

   function automatic string ref_tag(input logic [47:0] a, input logic [7:0] cfg);
      if (cfg[4]) return "R2";
      if (a == '1) return "R3";
      if (a[0]) return "R4";
      return "R6";
   endfunction

   task automatic tbl_wr(input bit sel, input int idx, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_idx = 3'(idx); wr_data = d;
      if (!sel && idx < 6) sta_m[8*idx +: 8] = d;
      if (sel) msk_m[8*idx +: 8] = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic drive_byte(input bit sof, input logic [7:0] d);
      @(negedge clk);
      in_valid = 1; in_sof = sof; in_data = d;
   endtask

   // Streams six bytes (optionally after leading bytes already sent), then waits
   // for the verdict, checking latency; junk bytes are offered while busy if asked.
   task automatic finish_frame(input logic [47:0] a, input bit junk, output bit acc);
      int lat = 0;
      for (int i = 0; i < 6; i++) drive_byte(i == 0, a[8*i +: 8]);
      @(negedge clk);
      in_valid = 0; in_sof = 0;
      check("R8 busy after sixth byte", busy, 1);
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         if (done) begin lat = k; break; end
         if (junk && k < 40) begin
            in_valid = 1; in_sof = (k % 7 == 0); in_data = 8'(k * 37);
         end else begin
            in_valid = 0; in_sof = 0;
         end
      end
      in_valid = 0; in_sof = 0;
      check("R7 verdict latency", lat, 49);
      acc = accept;
      @(negedge clk);
      check("R7 done one cycle", done, 0);
      check("R7 accept only with done", accept, 0);
   endtask

   task automatic run_frame(input logic [47:0] a, input logic [7:0] cfg, input string tag);
      bit acc;
      rx_cfg = cfg;
      finish_frame(a, 0, acc);
      check(tag, acc, ref_accept(a, cfg));
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [47:0] mc1, mc2;
      logic [5:0]  h;
      bit acc;
      repeat (3) @(negedge clk);
      check("R1 done at reset", done, 0);
      check("R1 accept at reset", accept, 0);
      check("R1 busy at reset", busy, 0);
      rst_n = 1;
      // R10: load station address
      for (int i = 0; i < 6; i++) tbl_wr(0, i, STA[8*i +: 8]);

      for (int v = 0; v < NVEC; v++)
         run_frame(VECS[v][47:0], VECS[v][55:48], ref_tag(VECS[v][47:0], VECS[v][55:48]));

      // R4/R5: only the hashed mask bit set -> hit; all others set -> miss
      mc1 = 48'h0100_005E_0001;
      h = ref_hash(mc1);
      tbl_wr(1, int'(h >> 3), 8'(1 << h[2:0]));
      run_frame(mc1, 8'h08, "R5 hash selects mask bit");
      run_frame(mc1, 8'h00, "R4 multicast disabled");
      tbl_wr(1, int'(h >> 3), ~8'(1 << h[2:0]));
      for (int i = 0; i < 8; i++) if (i != int'(h >> 3)) tbl_wr(1, i, 8'hFF);
      run_frame(mc1, 8'h08, "R5 neighbouring mask bits miss");
      mc2 = 48'h0100_0000_3333;
      for (int i = 0; i < 8; i++) tbl_wr(1, i, 8'h00);
      h = ref_hash(mc2);
      tbl_wr(1, int'(h >> 3), 8'(1 << h[2:0]));
      run_frame(mc2, 8'h08, "R5 second multicast hit");

      // R9: restart mid-address and stray byte without sof in idle
      rx_cfg = 8'h00;
      drive_byte(0, 8'h02);
      drive_byte(1, 8'hAA);
      drive_byte(0, 8'hBB);
      drive_byte(0, 8'hCC);
      finish_frame(STA, 0, acc);
      check("R9 restart on sof", acc, 1);

      // R8: junk during busy does not change verdict
      rx_cfg = 8'h00;
      finish_frame(STA, 1, acc);
      check("R8 bytes ignored while busy", acc, 1);
      check("R8 no spurious verdict", done, 0);
      repeat (60) @(negedge clk);
      check("R8 no late verdict", busy, 0);

      // R10: out-of-range station index ignored
      tbl_wr(0, 6, 8'h99);
      tbl_wr(0, 7, 8'h77);
      run_frame(STA, 8'h00, "R10 station intact after idx 6/7");
      tbl_wr(0, 5, 8'h66);
      run_frame(48'h6644_3322_1102, 8'h00, "R10 station byte 5 rewritten");

      finished = 1;
      summary();
   end
endmodule